// File: doc/BRIEF.md
# Buffered Bulk-Program Flash Engine

This block is the device-side controller for a streaming bulk-programming mode of a word-wide flash model. The host enters the mode with a two-write handshake. It then streams data words into a write buffer of fixed size. Each time the buffer is full, the engine pushes its whole content out through a simple array write stream. Successive buffers land on consecutive array words, so the first buffer starts at the entry address and each later buffer continues where the previous one stopped. The host watches progress and errors through an 8-bit status word.

The entry handshake works as follows. The host writes the setup opcode to an address. It then writes the confirm opcode to the same address. At confirm time the engine checks three things:
- the programming-voltage flag is good,
- the block is not locked,
- the address is aligned to the buffer size.

If any check fails, the engine sets sticky error flags and stays in normal operation. If all checks pass, the fill phase begins. Fills always write buffer slots 0 upward, whatever the low address bits are. Host writes that arrive while a buffer is being committed are dropped. The host leaves the mode by writing any address outside the block it entered. If that write comes in the middle of a fill, the partial buffer is thrown away.

Both data paths use valid/ready handshakes:
- **Host write stream.** The engine holds `wr_ready` high at all times. A write counts as taken on any clock edge where `wr_valid` is high. Whether the engine uses or drops that write depends only on its internal phase.
- **Array write stream.** `arr_valid` stays high while a buffer is being committed. When `arr_ready` is low, the engine holds `arr_addr` and `arr_data` unchanged. A word moves only on an edge where both `arr_valid` and `arr_ready` are high.

After the last word of a buffer moves, the engine waits a fixed settle time of `PROG_CYCLES` cycles. It then frees the buffer for the next fill.

Top module: `bulk_prog_engine`

## Requirements
- R1: After reset, `status` reads 0x80 and `arr_valid` is low.
- R2: The mode is entered only when a write carrying `SETUP_OP` is followed by the next write carrying `CONFIRM_OP` to the same address, with all checks passing. Once entered, `status` reads 0x00: bit 7 (ready) is 0 and bit 0 (buffer busy) is 0. If the confirm write does not match, the engine returns to normal operation and status stays 0x80.
- R3: A confirm address whose low log2(`BUF_WORDS`) bits are not zero aborts entry. It sets bit 4 (program failure) and bit 7 stays 1, so status reads 0x90.
- R4: If `vpp_good` is low at confirm, entry aborts and bits 3 and 4 are set. If `blk_locked` is high at confirm, entry aborts and bits 1 and 4 are set.
- R5: Each in-block write during a fill stores its data in the next buffer slot, starting at slot 0. After the `BUF_WORDS`-th write, bit 0 becomes 1 and the array stream emits all slots in slot order. The first buffer goes to consecutive addresses starting at the entry address. Each later buffer continues from where the previous one ended.
- R6: While bit 0 is 1, every host write is ignored. This includes writes outside the block, which do not end the mode.
- R7: While the mode is active, a write whose data equals an opcode value is stored as ordinary data.
- R8: During a fill, a write outside the current block (blocks are `BLK_WORDS`-aligned ranges) ends the mode. Status bit 7 reads 1 in the next cycle, and the partly filled buffer never reaches the array.
- R9: While `arr_ready` is low, `arr_valid` stays high and `arr_addr`/`arr_data` do not change. After the last word of a buffer is accepted, bit 0 stays 1 for `PROG_CYCLES` more cycles and then clears.
- R10: Error bits 1, 3 and 4 stay set until `clr_status` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Host write accept (always 1) |
| wr_addr | input | AW | Host word address |
| wr_data | input | DW | Host write data |
| vpp_good | input | 1 | Programming voltage is in range |
| blk_locked | input | 1 | Addressed block is write-protected |
| clr_status | input | 1 | Clears the sticky error bits |
| status | output | 8 | Status word: 7 ready, 4 fail, 3 voltage error, 1 lock error, 0 buffer busy |
| arr_valid | output | 1 | Array write word is present |
| arr_ready | input | 1 | Array accepts the word |
| arr_addr | output | AW | Array word address |
| arr_data | output | DW | Array word data |

## Verification
Two functions can coincide in the same cycle: a host write arriving on the clock edge where the settle wait ends and the buffer is released. The bench provokes this by holding an out-of-block write on the bus for every cycle that bit 0 reads 1, and releasing it only after it observes bit 0 cleared. The write held on the release edge is therefore still classed as busy. The bench judges the result by checking that the mode stays active (status 0x00 rather than 0x80), and that the next buffer still starts at slot 0 and lands on the expected array addresses. Array back-pressure from a pseudo-random ready pattern runs across every commit, and the scoreboard compares each emitted word in order.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_FILL,
    S_PROG,
    S_WAIT
  } bpe_state_e;

  localparam int ST_READY = 7;
  localparam int ST_FAIL  = 4;
  localparam int ST_VPP   = 3;
  localparam int ST_LOCK  = 1;
  localparam int ST_BUSY  = 0;
endpackage

// File: rtl/bpe_blk_chk.sv
module bpe_blk_chk #(
  parameter int TW = 5,
  parameter int LW = 9
) (
  input  logic [TW-1:0] tag_in,
  input  logic [TW-1:0] cur_tag,
  input  logic [LW-1:0] low_in,
  output logic          in_blk,
  output logic          aligned
);
  assign in_blk  = (tag_in == cur_tag);
  assign aligned = (low_in == '0);
endmodule

// File: rtl/bpe_wbuf.sv
module bpe_wbuf #(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bpe_ctrl.sv
module bpe_ctrl
  import bpe_pkg::*;
#(
  parameter int          AW          = 16,
  parameter int          DW          = 16,
  parameter int          BUF_WORDS   = 512,
  parameter int          BLK_WORDS   = 2048,
  parameter int          PROG_CYCLES = 20,
  parameter int unsigned SETUP_OP    = 'h80,
  parameter int unsigned CONFIRM_OP  = 'hD0,
  localparam int BIDX = $clog2(BUF_WORDS),
  localparam int BLKB = $clog2(BLK_WORDS),
  localparam int TW   = AW - BLKB,
  localparam int WCW  = $clog2(PROG_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            vpp_good,
  input  logic            blk_locked,
  input  logic            clr_status,
  input  logic            arr_ready,
  output logic [7:0]      status,
  output logic            arr_valid,
  output logic [AW-1:0]   arr_addr,
  output logic            buf_we,
  output logic [BIDX-1:0] buf_widx,
  output logic [BIDX-1:0] buf_ridx
);
  localparam logic [BIDX-1:0] LAST_IDX = BIDX'(BUF_WORDS - 1);
  localparam logic [WCW-1:0]  WAIT_END = WCW'(PROG_CYCLES - 1);

  bpe_state_e    state;
  logic [BIDX-1:0] fill_idx, prog_idx;
  logic [WCW-1:0]  wait_cnt;
  logic [AW-1:0]   setup_addr, arr_base;
  logic [TW-1:0]   blk_tag;
  logic            err_fail, err_vpp, err_lock;
  logic            in_blk, aligned;
  logic            active, busy;

  bpe_blk_chk #(.TW(TW), .LW(BIDX)) u_chk (
    .tag_in  (wr_addr[AW-1:BLKB]),
    .cur_tag (blk_tag),
    .low_in  (wr_addr[BIDX-1:0]),
    .in_blk  (in_blk),
    .aligned (aligned)
  );

  assign active = (state == S_FILL) || busy;
  assign busy   = (state == S_PROG) || (state == S_WAIT);

  always_comb begin
    status           = '0;
    status[ST_READY] = ~active;
    status[ST_FAIL]  = err_fail;
    status[ST_VPP]   = err_vpp;
    status[ST_LOCK]  = err_lock;
    status[ST_BUSY]  = busy;
  end

  assign arr_valid = (state == S_PROG);
  assign arr_addr  = arr_base + AW'(prog_idx);
  assign buf_we    = (state == S_FILL) && wr_valid && in_blk;
  assign buf_widx  = fill_idx;
  assign buf_ridx  = prog_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      fill_idx   <= '0;
      prog_idx   <= '0;
      wait_cnt   <= '0;
      setup_addr <= '0;
      arr_base   <= '0;
      blk_tag    <= '0;
      err_fail   <= 1'b0;
      err_vpp    <= 1'b0;
      err_lock   <= 1'b0;
    end else begin
      if (clr_status) begin
        err_fail <= 1'b0;
        err_vpp  <= 1'b0;
        err_lock <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          if (wr_valid && wr_data == DW'(SETUP_OP)) begin
            setup_addr <= wr_addr;
            state      <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (wr_valid) begin
            if (wr_data == DW'(CONFIRM_OP) && wr_addr == setup_addr) begin
              if (!vpp_good || blk_locked || !aligned) begin
                err_fail <= 1'b1;
                if (!vpp_good) err_vpp <= 1'b1;
                if (blk_locked) err_lock <= 1'b1;
                state <= S_IDLE;
              end else begin
                fill_idx <= '0;
                blk_tag  <= wr_addr[AW-1:BLKB];
                arr_base <= wr_addr;
                state    <= S_FILL;
              end
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_FILL: begin
          if (wr_valid) begin
            if (!in_blk) begin
              state <= S_IDLE;
            end else if (fill_idx == LAST_IDX) begin
              prog_idx <= '0;
              state    <= S_PROG;
            end else begin
              fill_idx <= fill_idx + 1'b1;
            end
          end
        end
        S_PROG: begin
          if (arr_ready) begin
            if (prog_idx == LAST_IDX) begin
              wait_cnt <= '0;
              arr_base <= arr_base + AW'(BUF_WORDS);
              state    <= S_WAIT;
            end else begin
              prog_idx <= prog_idx + 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (wait_cnt == WAIT_END) begin
            fill_idx <= '0;
            state    <= S_FILL;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ABORT_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_fail) |-> status[ST_READY]); // R3
  AST_ARR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |-> status[ST_BUSY]); // R5
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid) |=> !status[ST_READY]); // R6
  AST_EXIT_ON_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && wr_valid && !in_blk) |=> (status[ST_READY] && !arr_valid)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_fail && !clr_status) |=> err_fail); // R10
endmodule

// File: rtl/bulk_prog_engine.sv
module bulk_prog_engine #(
  parameter int          AW          = 16,
  parameter int          DW          = 16,
  parameter int          BUF_WORDS   = 512,
  parameter int          BLK_WORDS   = 2048,
  parameter int          PROG_CYCLES = 20,
  parameter int unsigned SETUP_OP    = 'h80,
  parameter int unsigned CONFIRM_OP  = 'hD0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          vpp_good,
  input  logic          blk_locked,
  input  logic          clr_status,
  output logic [7:0]    status,
  output logic          arr_valid,
  input  logic          arr_ready,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data
);
  localparam int BIDX = $clog2(BUF_WORDS);

  logic            buf_we;
  logic [BIDX-1:0] buf_widx, buf_ridx;

  assign wr_ready = 1'b1;

  bpe_ctrl #(
    .AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS), .BLK_WORDS(BLK_WORDS),
    .PROG_CYCLES(PROG_CYCLES), .SETUP_OP(SETUP_OP), .CONFIRM_OP(CONFIRM_OP)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .vpp_good   (vpp_good),
    .blk_locked (blk_locked),
    .clr_status (clr_status),
    .arr_ready  (arr_ready),
    .status     (status),
    .arr_valid  (arr_valid),
    .arr_addr   (arr_addr),
    .buf_we     (buf_we),
    .buf_widx   (buf_widx),
    .buf_ridx   (buf_ridx)
  );

  bpe_wbuf #(.DEPTH(BUF_WORDS), .DW(DW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_widx),
    .wdata (wr_data),
    .raddr (buf_ridx),
    .rdata (arr_data)
  );

  AST_ARR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !arr_ready) |=> (arr_valid && $stable(arr_addr) && $stable(arr_data))); // R9
endmodule

// File: tb/sim_bulk_prog_engine.sv
`timescale 1ns/1ps
module sim_bulk_prog_engine;
  localparam int AW = 16, DW = 16, BUFW = 512, PC = 20;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr_valid = 1'b0, wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          vpp_good = 1'b1, blk_locked = 1'b0, clr_status = 1'b0;
  logic [7:0]    status;
  logic          arr_valid, arr_ready = 1'b0;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  int checks = 0, fails = 0, hs_cnt = 0;
  logic [31:0] exp_q [$];
  logic [7:0]  lfsr = 8'h5A;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bulk_prog_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .vpp_good(vpp_good),
    .blk_locked(blk_locked), .clr_status(clr_status), .status(status),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_addr(arr_addr),
    .arr_data(arr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: choose ready for the coming edge, then pop and compare on a handshake
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      arr_ready = lfsr[0] | lfsr[1];
      if (arr_valid && arr_ready) begin
        hs_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5/R8 unexpected array word", {arr_addr, arr_data}, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk({arr_addr, arr_data} == e, "R5 array word", {arr_addr, arr_data}, e);
        end
      end
    end
  end

  task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
  endtask

  task automatic enter(input logic [AW-1:0] a);
    host_wr(a, 16'h0080);
    host_wr(a, 16'h00D0);
  endtask

  // fill one buffer; host addresses walk backward inside the block, array words go sequential
  task automatic fill_buf(input logic [AW-1:0] blk_base, input logic [AW-1:0] arr_start, input logic [DW-1:0] seed);
    for (int i = 0; i < BUFW; i++) begin
      logic [DW-1:0] d;
      d = seed + DW'(i * 7);
      if (i == 3) d = 16'h00D0;   // R7 opcode values stored as data
      if (i == 4) d = 16'h0080;
      exp_q.push_back({arr_start + AW'(i), d});
      host_wr(blk_base + AW'(BUFW - 1 - i), d);
      if (i == 4) chk(status == 8'h00, "R7 opcode data keeps mode", status, 8'h00);
    end
    chk(status == 8'h01, "R5 busy after full buffer", status, 8'h01);
  endtask

  // hold a foreign write for the whole busy span, count cycles after the last array word
  task automatic busy_wait();
    int tail = 0;
    forever begin
      @(negedge clk); #1;
      if (status[0]) begin
        wr_valid = 1'b1; wr_addr = 16'h0000; wr_data = 16'h1111;
        if (exp_q.size() == 0) tail++;
      end else begin
        wr_valid = 1'b0;
        break;
      end
    end
    chk(tail == PC + 1, "R9 settle length", tail, PC + 1);
    chk(status == 8'h00, "R6 foreign writes while busy ignored", status, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h80, "R1 reset status", status, 8'h80);
    chk(arr_valid == 1'b0, "R1 reset array idle", arr_valid, 0);
    chk(wr_ready == 1'b1, "R1 write ready", wr_ready, 1);

    enter(16'h0805);
    chk(status == 8'h90, "R3 misaligned start", status, 8'h90);
    pulse_clr();
    chk(status == 8'h80, "R10 clear", status, 8'h80);

    vpp_good = 1'b0;
    enter(16'h0800);
    vpp_good = 1'b1;
    chk(status == 8'h98, "R4 bad voltage", status, 8'h98);
    repeat (10) @(negedge clk);
    chk(status == 8'h98, "R10 sticky errors", status, 8'h98);
    pulse_clr();
    chk(status == 8'h80, "R10 cleared", status, 8'h80);

    blk_locked = 1'b1;
    enter(16'h0800);
    blk_locked = 1'b0;
    chk(status == 8'h92, "R4 locked block", status, 8'h92);
    pulse_clr();

    host_wr(16'h0800, 16'h0080);
    host_wr(16'h0801, 16'h00D0);
    chk(status == 8'h80, "R2 confirm address mismatch", status, 8'h80);
    host_wr(16'h0800, 16'h1234);
    chk(status == 8'h80, "R2 stray write no entry", status, 8'h80);

    enter(16'h0800);
    chk(status == 8'h00, "R2 mode entered", status, 8'h00);
    fill_buf(16'h0800, 16'h0800, 16'h1000);
    busy_wait();
    fill_buf(16'h0800, 16'h0A00, 16'h4000);
    busy_wait();
    host_wr(16'h0000, 16'hFFFF);
    chk(status == 8'h80, "R8 exit on foreign block", status, 8'h80);
    chk(exp_q.size() == 0, "R5 all words committed", exp_q.size(), 0);

    enter(16'h1000);
    for (int i = 0; i < 100; i++) host_wr(16'h1000 + AW'(i), 16'hBEEF);
    begin
      int h0;
      h0 = hs_cnt;
      host_wr(16'h0000, 16'hFFFF);
      chk(status == 8'h80, "R8 exit mid fill", status, 8'h80);
      repeat (30) @(negedge clk);
      chk(hs_cnt == h0, "R8 partial buffer discarded", hs_cnt, h0);
    end

    enter(16'h1000);
    fill_buf(16'h1000, 16'h1000, 16'h7000);
    busy_wait();
    host_wr(16'h2000, 16'hFFFF);
    chk(status == 8'h80, "R8 exit after refill", status, 8'h80);
    chk(exp_q.size() == 0, "R5 refill starts at slot 0", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule